// File: doc/BRIEF.md
# Fetch and Interrupt Sequencer

This block is the control core of a small 8-bit processor. It holds the decoder state, which is an opcode in the upper bits and a 3-bit step count below it. It raises a fetch strobe in the last execution cycle of every instruction. At the edge that closes that cycle it loads either the byte on the data bus or, when a request is due, the break opcode. A forced break carries a tag that says whether it serves reset, a non-maskable request, or a maskable request. A break fetched from the program carries a different tag. Reset, both interrupt kinds and the program's own break all run through one 7-step break sequence. That sequence drives the stack-push write enable, the break bit of the pushed status byte, the vector address and the pulse that sets the interrupt-disable flag.

The surrounding datapath reports the end of each ordinary instruction through `instr_end` and marks conditional branches through `instr_branch`. It holds the interrupt-disable flag and feeds it back on `i_flag`. No stream of data passes through the block, so every pin is a plain control or status level. There is no valid/ready handshake and no back-pressure.

Top module: `fetch_int_seq`

## Requirements
- R1: While `rst_n` is low, `ir_op` is 0x00, `ir_step` is 0, `sync` is 0, `push_wr` is 0 and `int_kind` is 4 (reset). Kind codes: 0 none, 1 program break, 2 maskable, 3 non-maskable, 4 reset.
- R2: In the cycle after `sync` is high, `ir_step` is 0 and `ir_op` holds the `bus_din` byte sampled at the closing edge, unless a request is taken. In every other cycle `ir_step` rises by one.
- R3: For a non-break opcode, `sync` equals `instr_end`. For opcode 0x00 the sequence always lasts 7 cycles (steps 0 to 6), with `sync` high only in step 6, and `instr_end` and `instr_branch` are ignored.
- R4: In steps 1 to 3 of a break sequence, `push_wr` is high unless the kind is reset.
- R5: In step 4 `vec_addr` is 0xFFFA for non-maskable, 0xFFFC for reset and 0xFFFE otherwise. In step 5 it is that value plus one, and `set_i` is high in step 5.
- R6: Opcode 0x00 loaded from the bus gives kind 1, and `status_brk` is high in step 3. In a hardware-forced sequence `status_brk` stays low in step 3.
- R7: A low `irq_n` is not served while `i_flag` is high.
- R8: For a non-branch instruction, a request present in the second-to-last cycle is served at that boundary. A request that first appears in the last cycle waits for the next boundary.
- R9: When `instr_branch` is high in the last cycle, a request that first appears in that last cycle is served at that boundary.
- R10: A high-to-low change on `nmi_n` is latched, even as a one-cycle pulse, and is served whatever `i_flag` is. The latch is cleared when step 4 of a non-maskable sequence is reached, so the request is served only once.
- R11: If a non-maskable request is latched by step 3 of a maskable sequence, the sequence finishes as non-maskable (kind 3, vector 0xFFFA). If it is latched later, it is served at the next boundary.
- R12: After reset is released, the block runs a 7-cycle break sequence with kind 4 and vector 0xFFFC before the first opcode fetch, and `push_wr` stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_din | input | 8 | Data bus byte, holds the next opcode during the `sync` cycle |
| irq_n | input | 1 | Maskable request, active-low level |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| i_flag | input | 1 | Interrupt-disable flag from the datapath |
| instr_end | input | 1 | This cycle is the last of the current ordinary instruction |
| instr_branch | input | 1 | Current instruction is a conditional branch |
| sync | output | 1 | Last execution cycle; the opcode fetch overlaps it |
| ir_op | output | 8 | Current opcode |
| ir_step | output | 3 | Step within the current instruction |
| int_kind | output | 3 | Kind tag of the current instruction |
| push_wr | output | 1 | Stack push is a write in this cycle |
| status_brk | output | 1 | Break bit of the status byte pushed in this cycle |
| vec_addr | output | 16 | Vector byte address in steps 4 and 5, zero otherwise |
| set_i | output | 1 | Set the interrupt-disable flag |

## Verification
Several properties are checked on every cycle:
- the step count restarts after `sync` and advances otherwise;
- an opcode taken from the bus matches the sampled byte;
- a break sequence never passes step 6;
- the two vector bytes are consecutive;
- the reset sequence never writes;
- the non-maskable latch only rises after a low input and holds until it is served;
- a maskable tag never turns non-maskable after step 3.

Other behaviours depend on where a request arrives relative to an instruction boundary, and only the bench's scenarios can show them. These are the two-cycle and branch-shortened sampling windows, the masking by `i_flag`, the hand-over from a maskable to a non-maskable sequence, and a late non-maskable request being served directly after a maskable sequence.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    KIND_NONE  = 3'd0,
    KIND_SOFT  = 3'd1,
    KIND_IRQ   = 3'd2,
    KIND_NMI   = 3'd3,
    KIND_RESET = 3'd4
  } int_kind_e;

  localparam logic [7:0] VLO_NMI = 8'hFA;
  localparam logic [7:0] VLO_RST = 8'hFC;
  localparam logic [7:0] VLO_IRQ = 8'hFE;

  function automatic logic [7:0] vec_lo(input int_kind_e k);
    case (k)
      KIND_NMI:   return VLO_NMI;
      KIND_RESET: return VLO_RST;
      default:    return VLO_IRQ;
    endcase
  endfunction

endpackage

// File: rtl/seq_int_detect.sv
module seq_int_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic nmi_n,
  input  logic i_flag,
  input  logic nmi_clear,
  output logic nmi_pend,
  output logic req_now,
  output logic req_poll
);

  logic nmi_prev;
  logic nmi_fall;

  assign nmi_fall = nmi_prev & ~nmi_n;
  assign req_now  = nmi_pend | (~irq_n & ~i_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_prev <= 1'b1;
      nmi_pend <= 1'b0;
      req_poll <= 1'b0;
    end else begin
      nmi_prev <= nmi_n;
      req_poll <= req_now;
      if (nmi_fall)       nmi_pend <= 1'b1;
      else if (nmi_clear) nmi_pend <= 1'b0;
    end
  end

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (nmi_pend && !nmi_clear) |=> nmi_pend); // R10
  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(nmi_pend) |-> $past(!nmi_n)); // R10

endmodule

// File: rtl/seq_ir.sv
module seq_ir
  import seq_pkg::*;
#(
  parameter int              OP_W        = 8,
  parameter int              STEP_W      = 3,
  parameter logic [OP_W-1:0] BRK_OP      = '0,
  parameter int              HIJACK_LAST = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   din,
  input  logic              sync,
  input  logic              take,
  input  logic              nmi_pend,
  output logic [OP_W-1:0]   op,
  output logic [STEP_W-1:0] ir_step,
  output int_kind_e         kind
);

  localparam logic [STEP_W-1:0] S_HIJ = STEP_W'(HIJACK_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op      <= BRK_OP;
      ir_step <= '0;
      kind    <= KIND_RESET;
    end else if (sync) begin
      ir_step <= '0;
      if (take) begin
        op   <= BRK_OP;
        kind <= nmi_pend ? KIND_NMI : KIND_IRQ;
      end else begin
        op   <= din;
        kind <= (din == BRK_OP) ? KIND_SOFT : KIND_NONE;
      end
    end else begin
      ir_step <= ir_step + 1'b1;
      if (kind == KIND_IRQ && nmi_pend && ir_step <= S_HIJ)
        kind <= KIND_NMI;
    end
  end

  AST_STEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n) sync |=> (ir_step == '0)); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) !sync |=> (ir_step == $past(ir_step) + 1'b1)); // R2
  AST_OP_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n) (sync && !take) |=> (op == $past(din))); // R2
  AST_HIJACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) (kind == KIND_IRQ && !sync && ir_step > S_HIJ) |=> (kind == KIND_IRQ)); // R11

endmodule

// File: rtl/seq_step_decode.sv
module seq_step_decode
  import seq_pkg::*;
#(
  parameter int              OP_W      = 8,
  parameter int              STEP_W    = 3,
  parameter int              ADDR_W    = 16,
  parameter logic [OP_W-1:0] BRK_OP    = '0,
  parameter int              LAST_STEP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op,
  input  logic [STEP_W-1:0] ir_step,
  input  int_kind_e         kind,
  input  logic              instr_end,
  input  logic              instr_branch,
  input  logic              req_now,
  input  logic              req_poll,
  output logic              sync,
  output logic              take,
  output logic              push_wr,
  output logic              status_brk,
  output logic              set_i,
  output logic              nmi_clear,
  output logic [ADDR_W-1:0] vec_addr
);

  localparam logic [STEP_W-1:0] S_LAST   = STEP_W'(LAST_STEP);
  localparam logic [STEP_W-1:0] S_PFIRST = STEP_W'(1);
  localparam logic [STEP_W-1:0] S_PLAST  = STEP_W'(LAST_STEP - 3);
  localparam logic [STEP_W-1:0] S_VLO    = STEP_W'(LAST_STEP - 2);
  localparam logic [STEP_W-1:0] S_VHI    = STEP_W'(LAST_STEP - 1);

  logic       in_brk;
  logic [7:0] lo;

  assign in_brk = (op == BRK_OP);

  always_comb begin
    // break sequences time themselves; ordinary opcodes follow the datapath
    sync = in_brk ? (ir_step == S_LAST) : instr_end;
    // branches may sample the request one cycle later than other opcodes
    if (!in_brk && instr_branch) take = sync & req_now;
    else                         take = sync & req_poll;
  end

  always_comb begin
    push_wr    = in_brk && ir_step >= S_PFIRST && ir_step <= S_PLAST && kind != KIND_RESET;
    status_brk = in_brk && ir_step == S_PLAST && kind == KIND_SOFT;
    set_i      = in_brk && ir_step == S_VHI;
    nmi_clear  = in_brk && ir_step == S_VLO && kind == KIND_NMI;
    lo         = vec_lo(kind);
    if (ir_step == S_VHI) lo = lo | 8'h01;
    if (in_brk && (ir_step == S_VLO || ir_step == S_VHI))
      vec_addr = {{(ADDR_W-8){1'b1}}, lo};
    else
      vec_addr = '0;
  end

  AST_RESET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (kind == KIND_RESET) |-> !push_wr); // R12
  AST_BRK_BOUND: assert property (@(posedge clk) disable iff (!rst_n) in_brk |-> (ir_step <= S_LAST)); // R3
  AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (in_brk && ir_step == S_VLO) |=> (vec_addr == $past(vec_addr) + 1'b1)); // R5

endmodule

// File: rtl/fetch_int_seq.sv
module fetch_int_seq
  import seq_pkg::*;
#(
  parameter int              OP_W       = 8,
  parameter int              STEP_W     = 3,
  parameter int              ADDR_W     = 16,
  parameter logic [OP_W-1:0] BRK_OP     = '0,
  parameter int              BRK_CYCLES = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   bus_din,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              i_flag,
  input  logic              instr_end,
  input  logic              instr_branch,
  output logic              sync,
  output logic [OP_W-1:0]   ir_op,
  output logic [STEP_W-1:0] ir_step,
  output logic [2:0]        int_kind,
  output logic              push_wr,
  output logic              status_brk,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              set_i
);

  localparam int LAST_STEP   = BRK_CYCLES - 1;
  localparam int HIJACK_LAST = LAST_STEP - 3;

  logic      take;
  logic      nmi_pend;
  logic      nmi_clear;
  logic      req_now;
  logic      req_poll;
  int_kind_e kind;

  seq_int_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n),
    .nmi_n     (nmi_n),
    .i_flag    (i_flag),
    .nmi_clear (nmi_clear),
    .nmi_pend  (nmi_pend),
    .req_now   (req_now),
    .req_poll  (req_poll)
  );

  seq_ir #(
    .OP_W        (OP_W),
    .STEP_W      (STEP_W),
    .BRK_OP      (BRK_OP),
    .HIJACK_LAST (HIJACK_LAST)
  ) u_ir (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (bus_din),
    .sync     (sync),
    .take     (take),
    .nmi_pend (nmi_pend),
    .op       (ir_op),
    .ir_step  (ir_step),
    .kind     (kind)
  );

  seq_step_decode #(
    .OP_W      (OP_W),
    .STEP_W    (STEP_W),
    .ADDR_W    (ADDR_W),
    .BRK_OP    (BRK_OP),
    .LAST_STEP (LAST_STEP)
  ) u_dec (
    .clk          (clk),
    .rst_n        (rst_n),
    .op           (ir_op),
    .ir_step      (ir_step),
    .kind         (kind),
    .instr_end    (instr_end),
    .instr_branch (instr_branch),
    .req_now      (req_now),
    .req_poll     (req_poll),
    .sync         (sync),
    .take         (take),
    .push_wr      (push_wr),
    .status_brk   (status_brk),
    .set_i        (set_i),
    .nmi_clear    (nmi_clear),
    .vec_addr     (vec_addr)
  );

  assign int_kind = kind;

endmodule

// File: tb/tb_fetch_int_seq.sv
module tb_fetch_int_seq;

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_din;
  logic        irq_n;
  logic        nmi_n;
  logic        i_flag;
  logic        instr_end;
  logic        instr_branch;
  logic        sync;
  logic [7:0]  ir_op;
  logic [2:0]  ir_step;
  logic [2:0]  int_kind;
  logic        push_wr;
  logic        status_brk;
  logic [15:0] vec_addr;
  logic        set_i;

  int checks = 0;
  int fails  = 0;
  logic [10:0] expq[$];
  string       tagq[$];
  logic        prev_sync;

  fetch_int_seq dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_din      (bus_din),
    .irq_n        (irq_n),
    .nmi_n        (nmi_n),
    .i_flag       (i_flag),
    .instr_end    (instr_end),
    .instr_branch (instr_branch),
    .sync         (sync),
    .ir_op        (ir_op),
    .ir_step      (ir_step),
    .int_kind     (int_kind),
    .push_wr      (push_wr),
    .status_brk   (status_brk),
    .vec_addr     (vec_addr),
    .set_i        (set_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // demonstration cycle plan: length 2 + op[1:0]; 0x9_ opcodes are branches.
  // During a break the plan lines are held high to show they are ignored.
  always_comb begin
    if (ir_op == 8'h00) begin
      instr_end    = 1'b1;
      instr_branch = 1'b1;
    end else begin
      instr_end    = (int'(ir_step) == 1 + int'(ir_op[1:0]));
      instr_branch = (ir_op[7:4] == 4'h9);
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // scoreboard monitor: pops one expected load after each fetch strobe
  always @(negedge clk) begin
    if (rst_n && prev_sync) begin
      if (expq.size() == 0) begin
        chk("R2", "unexpected load", {21'd0, ir_op, int_kind}, 32'h7FF);
      end else begin
        logic [10:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, "opcode", {24'd0, ir_op}, {24'd0, e[10:3]});
        chk(t, "kind", {29'd0, int_kind}, {29'd0, e[2:0]});
        chk("R2", "step after fetch", {29'd0, ir_step}, 32'd0);
      end
    end
    prev_sync <= rst_n & sync;
  end

  task automatic boundary(input logic [7:0] op, input logic [7:0] eop, input logic [2:0] ek, input string tag);
    while (!sync) @(negedge clk);
    bus_din = op;
    expq.push_back({eop, ek});
    tagq.push_back(tag);
    @(negedge clk);
  endtask

  task automatic at_step(input int s);
    while (int'(ir_step) != s) @(negedge clk);
  endtask

  task automatic watch_brk(input int vk, input bit wr, input bit stb, input int nmi_at, input string tag);
    logic [7:0] lo;
    lo = (vk == 3) ? 8'hFA : (vk == 4) ? 8'hFC : 8'hFE;
    for (int s = 0; s <= 6; s++) begin
      chk("R3", "break step", {29'd0, ir_step}, s);
      if (s == 0) irq_n = 1'b1;
      if (s == nmi_at) nmi_n = 1'b0;
      if (nmi_at >= 0 && s == nmi_at + 1) nmi_n = 1'b1;
      if (s >= 1 && s <= 3) chk(wr ? "R4" : tag, "push write", {31'd0, push_wr}, {31'd0, wr});
      if (s == 3) chk("R6", "status break bit", {31'd0, status_brk}, {31'd0, stb});
      if (s == 4) begin
        chk("R5", "vector low", {16'd0, vec_addr}, {16'd0, 8'hFF, lo});
        chk(tag, "kind at vector", {29'd0, int_kind}, vk);
      end
      if (s == 5) begin
        chk("R5", "vector high", {16'd0, vec_addr}, {16'd0, 8'hFF, lo | 8'h01});
        chk("R5", "set i", {31'd0, set_i}, 32'd1);
      end
      chk("R3", "sync in break", {31'd0, sync}, (s == 6) ? 32'd1 : 32'd0);
      if (s < 6) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; i_flag = 1'b0; bus_din = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "op", {24'd0, ir_op}, 32'h00);
    chk("R1", "step", {29'd0, ir_step}, 32'd0);
    chk("R1", "sync", {31'd0, sync}, 32'd0);
    chk("R1", "kind", {29'd0, int_kind}, 32'd4);
    chk("R1", "push", {31'd0, push_wr}, 32'd0);
    rst_n = 1'b1;
    // R12 reset runs the 7-cycle break path with reads only
    watch_brk(4, 1'b0, 1'b0, -1, "R12");

    // R2 plain loads of several lengths
    boundary(8'h03, 8'h03, 3'd0, "R2");
    boundary(8'h01, 8'h01, 3'd0, "R2");
    boundary(8'h02, 8'h02, 3'd0, "R2");

    // R6 program break
    boundary(8'h00, 8'h00, 3'd1, "R6");
    watch_brk(1, 1'b1, 1'b1, -1, "R6");

    // R7 masked level request
    i_flag = 1'b1;
    boundary(8'h02, 8'h02, 3'd0, "R7");
    irq_n = 1'b0;
    boundary(8'h01, 8'h01, 3'd0, "R7");
    boundary(8'h03, 8'h03, 3'd0, "R7");
    irq_n = 1'b1;
    boundary(8'h02, 8'h02, 3'd0, "R7");
    i_flag = 1'b0;

    // R8 request in second-to-last cycle is served
    boundary(8'h03, 8'h03, 3'd0, "R2");
    at_step(3);
    irq_n = 1'b0;
    boundary(8'hEA, 8'h00, 3'd2, "R8");
    watch_brk(2, 1'b1, 1'b0, -1, "R8");
    boundary(8'h01, 8'h01, 3'd0, "R2");

    // R8 request first in last cycle waits one instruction
    at_step(2);
    irq_n = 1'b0;
    boundary(8'h03, 8'h03, 3'd0, "R8");
    boundary(8'hEA, 8'h00, 3'd2, "R8");
    watch_brk(2, 1'b1, 1'b0, -1, "R8");
    boundary(8'h91, 8'h91, 3'd0, "R2");

    // R9 branch: last-cycle request is served
    at_step(2);
    irq_n = 1'b0;
    boundary(8'hEA, 8'h00, 3'd2, "R9");
    watch_brk(2, 1'b1, 1'b0, -1, "R9");
    boundary(8'h03, 8'h03, 3'd0, "R2");

    // R10 one-cycle falling pulse, served despite i_flag, served once
    i_flag = 1'b1;
    at_step(2);
    nmi_n = 1'b0;
    @(negedge clk);
    nmi_n = 1'b1;
    boundary(8'hEA, 8'h00, 3'd3, "R10");
    watch_brk(3, 1'b1, 1'b0, -1, "R10");
    boundary(8'h02, 8'h02, 3'd0, "R10");
    i_flag = 1'b0;

    // R11 early non-maskable takes over a maskable sequence
    at_step(2);
    irq_n = 1'b0;
    boundary(8'hEA, 8'h00, 3'd2, "R8");
    watch_brk(3, 1'b1, 1'b0, 1, "R11");
    boundary(8'h01, 8'h01, 3'd0, "R11");

    // R11 late non-maskable served right after the maskable sequence
    at_step(1);
    irq_n = 1'b0;
    boundary(8'hEA, 8'h00, 3'd2, "R8");
    watch_brk(2, 1'b1, 1'b0, 4, "R11");
    boundary(8'hEA, 8'h00, 3'd3, "R11");
    watch_brk(3, 1'b1, 1'b0, -1, "R11");
    boundary(8'h03, 8'h03, 3'd0, "R2");

    repeat (2) @(negedge clk);
    chk("R2", "pending expected loads", expq.size(), 32'd0);
    finish_run();
  end

endmodule